// File: doc/BRIEF.md
# Learning MAC Forwarding Table

This block decides where each received Ethernet frame should go. A request carries the frame's 48-bit destination and source addresses, the port it came in on and the current value of a free-running timestamp. The block first learns the source address, binding it to the ingress port and stamping it with the current time. It then looks up the destination address and answers with either one egress port or a flood mask that covers every port except the one the frame came in on.

Entries age out lazily. Only a source appearance refreshes an entry. A destination lookup checks the entry's age against a time-to-live input, and a stale hit is removed in the same cycle and treated as a miss. The table is a small, fully associative store. When it is full, a new source address takes over the entry whose timestamp is oldest relative to the current time.

Top module: `mac_fwd_table`

## Requirements
- R1: After reset the table holds no entries and `rsp_valid` is low, so the first lookup of any destination floods.
- R2: A request accepted with `req_valid` high at a clock edge produces `rsp_valid` high for exactly one cycle after that edge. `rsp_valid` is low in every cycle that does not follow a request.
- R3: Frame byte 0 sits in bits 47:40 of an address. The group bit is bit 40, and all-ones is broadcast. A destination with bit 40 set always floods, even when the same address has been learned as a source.
- R4: A source address that is not in the table creates an entry holding the ingress port and the request timestamp. A later lookup of that address returns a unicast to that port.
- R5: A source address already in the table only has its timestamp set to the request time. Its stored port does not change when the address arrives on a different port.
- R6: Learning comes before lookup within one request. When destination equals source, the answer is a unicast to the port now stored for that address.
- R7: A destination hit is honoured while (request time minus stored time, modulo 2^TS_W) is not greater than `ttl`. An age exactly equal to `ttl` still unicasts.
- R8: A hit whose age exceeds `ttl` floods, and the entry is removed. A later lookup of that address floods even after `ttl` is raised.
- R9: A destination lookup never refreshes the stored timestamp.
- R10: On a flood, `rsp_flood` is 1, `rsp_port` is 0 and `rsp_mask` bit i is 1 for every port i except the ingress port. On a unicast, `rsp_flood` is 0, `rsp_mask` is 0 and `rsp_port` is the egress port.
- R11: A new source takes the lowest-indexed free entry. When no entry is free, it replaces the entry with the largest age, and the lowest index wins a tie. A destination held in the replaced entry then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_dst | input | 48 | Destination address, byte 0 in bits 47:40 |
| req_src | input | 48 | Source address, byte 0 in bits 47:40 |
| req_port | input | PORT_W | Ingress port number |
| req_time | input | TS_W | Current timestamp |
| ttl | input | TS_W | Time-to-live for entries |
| rsp_valid | output | 1 | Result valid, one cycle per request |
| rsp_flood | output | 1 | 1 = flood, 0 = unicast |
| rsp_port | output | PORT_W | Egress port on unicast |
| rsp_mask | output | NUM_PORTS | Flood mask, one bit per port |

## Verification
Every result, and the table update that goes with it, belongs to the clock edge that accepts the request. The response fields are due one edge after `req_valid`. The bench drives each request on a falling edge and samples the response on the next falling edge, half a period after the registering edge. Each request is followed by one idle cycle, and `rsp_valid` is checked low there. The effect of a request on the table is observed through the responses to later requests, whose expected values come from a bench model of the learn, age and replace rules.

// File: rtl/mft_pkg.sv
package mft_pkg;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;

    function automatic logic mac_is_group(input logic [MAC_W-1:0] a);
        return a[GROUP_BIT];
    endfunction
endpackage

// File: rtl/mft_match.sv
module mft_match
    import mft_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][MAC_W-1:0]  keys,
    input  logic [MAC_W-1:0]               key,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] hv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hv[g] = vld[g] && (keys[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R4: learning never creates a second entry for an address
    p_unique_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hv));
endmodule

// File: rtl/mft_victim.sv
module mft_victim #(
    parameter int ENTRIES = 8,
    parameter int TS_W    = 32,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][TS_W-1:0]  ts,
    input  logic [TS_W-1:0]               now,
    output logic [IDX_W-1:0]              idx
);
    always_comb begin
        logic            got_free;
        logic            have;
        logic [TS_W-1:0] best;
        logic [TS_W-1:0] age;
        got_free = 1'b0;
        have     = 1'b0;
        best     = '0;
        idx      = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            age = now - ts[i];
            if (!got_free) begin
                if (!vld[i]) begin
                    got_free = 1'b1;
                    idx      = IDX_W'(i);
                end else if (!have || age > best) begin
                    have = 1'b1;
                    best = age;
                    idx  = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/mac_fwd_table.sv
module mac_fwd_table
    import mft_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ENTRIES   = 8,
    parameter int TS_W      = 32,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [47:0]           req_dst,
    input  logic [47:0]           req_src,
    input  logic [PORT_W-1:0]     req_port,
    input  logic [TS_W-1:0]       req_time,
    input  logic [TS_W-1:0]       ttl,
    output logic                  rsp_valid,
    output logic                  rsp_flood,
    output logic [PORT_W-1:0]     rsp_port,
    output logic [NUM_PORTS-1:0]  rsp_mask
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]              vld;
        logic [ENTRIES-1:0][MAC_W-1:0]   mac;
        logic [ENTRIES-1:0][PORT_W-1:0]  prt;
        logic [ENTRIES-1:0][TS_W-1:0]    ts;
        logic                            rsp_v;
        logic                            rsp_flood;
        logic [PORT_W-1:0]               rsp_port;
        logic [NUM_PORTS-1:0]            rsp_mask;
    } state_t;

    state_t st_d, st_q;

    logic             src_hit_d, dst_hit_q;
    logic [IDX_W-1:0] src_idx_d, dst_idx_q, vic_idx_d;

    // source search, destination search, replacement choice: all on the registered table
    mft_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_src_match (
        .clk(clk), .rst_n(rst_n), .vld(st_q.vld), .keys(st_q.mac),
        .key(req_src), .hit(src_hit_d), .idx(src_idx_d)
    );

    mft_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dst_match (
        .clk(clk), .rst_n(rst_n), .vld(st_q.vld), .keys(st_q.mac),
        .key(req_dst), .hit(dst_hit_q), .idx(dst_idx_q)
    );

    mft_victim #(.ENTRIES(ENTRIES), .TS_W(TS_W), .IDX_W(IDX_W)) u_victim (
        .vld(st_q.vld), .ts(st_q.ts), .now(req_time), .idx(vic_idx_d)
    );

    always_comb begin
        logic              alloc;
        logic              hit;
        logic [PORT_W-1:0] eport;
        logic [TS_W-1:0]   age;
        st_d           = st_q;
        st_d.rsp_v     = 1'b0;
        st_d.rsp_flood = 1'b0;
        st_d.rsp_port  = '0;
        st_d.rsp_mask  = '0;
        alloc = 1'b0;
        hit   = 1'b0;
        eport = '0;
        age   = '0;
        if (req_valid) begin
            // learn first (R4, R5)
            if (src_hit_d) begin
                st_d.ts[src_idx_d] = req_time;
            end else begin
                alloc                = 1'b1;
                st_d.vld[vic_idx_d]  = 1'b1;
                st_d.mac[vic_idx_d]  = req_src;
                st_d.prt[vic_idx_d]  = req_port;
                st_d.ts[vic_idx_d]   = req_time;
            end
            // then look up, seeing the freshly learned entry (R6)
            if (req_dst == req_src) begin
                hit   = 1'b1;
                eport = src_hit_d ? st_q.prt[src_idx_d] : req_port;
            end else if (dst_hit_q && !(alloc && vic_idx_d == dst_idx_q)) begin
                age   = req_time - st_q.ts[dst_idx_q];
                eport = st_q.prt[dst_idx_q];
                hit   = 1'b1;
                if (age > ttl) begin
                    // stale: drop it and fall back to flooding (R8)
                    hit                 = 1'b0;
                    st_d.vld[dst_idx_q] = 1'b0;
                end
            end
            st_d.rsp_v     = 1'b1;
            st_d.rsp_flood = !hit || mac_is_group(req_dst);
            if (st_d.rsp_flood) begin
                for (int i = 0; i < NUM_PORTS; i++) begin
                    st_d.rsp_mask[i] = (PORT_W'(i) != req_port);
                end
            end else begin
                st_d.rsp_port = eport;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_flood = st_q.rsp_flood;
    assign rsp_port  = st_q.rsp_port;
    assign rsp_mask  = st_q.rsp_mask;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_group_never_unicast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_flood) |-> !$past(req_dst[GROUP_BIT]));

    p_flood_excludes_ingress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_flood) |->
            (!rsp_mask[$past(req_port)] && $countones(rsp_mask) == NUM_PORTS - 1));

    p_unicast_port_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_flood) |-> (int'(rsp_port) < NUM_PORTS && rsp_mask == '0));
endmodule

// File: tb/mac_fwd_table_tb.sv
`timescale 1ns/1ps
module mac_fwd_table_tb;
    localparam int NP = 4;
    localparam int NE = 8;
    localparam int TW = 32;
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [47:0]   req_dst = '0, req_src = '0;
    logic [PW-1:0] req_port = '0;
    logic [TW-1:0] req_time = '0, ttl = '0;
    logic          rsp_valid, rsp_flood;
    logic [PW-1:0] rsp_port;
    logic [NP-1:0] rsp_mask;

    int checks = 0, failures = 0;
    bit done = 0;

    // model table
    bit            m_vld [NE];
    logic [47:0]   m_mac [NE];
    logic [PW-1:0] m_prt [NE];
    logic [TW-1:0] m_ts  [NE];

    always #2 clk = ~clk;

    mac_fwd_table #(.NUM_PORTS(NP), .ENTRIES(NE), .TS_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .req_src(req_src), .req_port(req_port), .req_time(req_time), .ttl(ttl),
        .rsp_valid(rsp_valid), .rsp_flood(rsp_flood), .rsp_port(rsp_port),
        .rsp_mask(rsp_mask)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [47:0] uaddr(int k);
        return {8'h02, 8'h00, 32'(k)};
    endfunction

    function automatic logic [NP-1:0] flood_mask(logic [PW-1:0] p);
        logic [NP-1:0] m;
        for (int i = 0; i < NP; i++) m[i] = (PW'(i) != p);
        return m;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_vld[i] = 0;
    endtask

    // expected answer from the learn / age / replace rules
    task automatic model_step(input logic [47:0] dst, src, input logic [PW-1:0] p,
                              output bit fl, output logic [PW-1:0] ep);
        int si = -1, di = -1, vi = -1;
        logic [TW-1:0] best = '0;
        for (int i = 0; i < NE; i++) if (m_vld[i] && m_mac[i] == src) si = i;
        if (si >= 0) m_ts[si] = req_time;
        else begin
            for (int i = 0; i < NE; i++) if (!m_vld[i] && vi < 0) vi = i;
            if (vi < 0) begin
                for (int i = 0; i < NE; i++)
                    if (vi < 0 || (req_time - m_ts[i]) > best) begin
                        vi = i; best = req_time - m_ts[i];
                    end
            end
            m_vld[vi] = 1; m_mac[vi] = src; m_prt[vi] = p; m_ts[vi] = req_time;
        end
        for (int i = 0; i < NE; i++) if (m_vld[i] && m_mac[i] == dst) di = i;
        ep = '0;
        fl = 1;
        if (di >= 0) begin
            if ((req_time - m_ts[di]) > ttl) m_vld[di] = 0;
            else begin fl = 0; ep = m_prt[di]; end
        end
        if (dst[40]) fl = 1;
        if (fl) ep = '0;
    endtask

    task automatic send(string tag, logic [47:0] dst, src, logic [PW-1:0] p);
        bit fl;
        logic [PW-1:0] ep;
        @(negedge clk);
        req_valid = 1; req_dst = dst; req_src = src; req_port = p;
        model_step(dst, src, p, fl, ep);
        @(negedge clk);
        req_valid = 0;
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(tag, "rsp_flood", 64'(rsp_flood), 64'(fl));
        chk(tag, "rsp_port", 64'(rsp_port), 64'(ep));
        chk(tag, "rsp_mask", 64'(rsp_mask), fl ? 64'(flood_mask(p)) : 64'd0);
        @(negedge clk);
        chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 0; req_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        ttl = 32'd1000; req_time = 32'd100;
        send("R1", uaddr(1), uaddr(9), 2'd0);          // empty table: flood
        send("R4", '1, uaddr(1), 2'd1);                  // learn A on port 1
        send("R4", uaddr(1), uaddr(2), 2'd2);            // A -> unicast 1
        send("R5", '1, uaddr(1), 2'd3);                  // A seen on port 3
        send("R5", uaddr(1), uaddr(2), 2'd0);            // still port 1
        send("R6", uaddr(3), uaddr(3), 2'd2);            // self lookup
        send("R3", {8'h03, 40'h0}, {8'h03, 40'h0}, 2'd1); // group address
        send("R3", 48'hFFFF_FFFF_FFFF, uaddr(2), 2'd3);
        // ageing: A refreshed at 200
        req_time = 32'd200; ttl = 32'd10;
        send("R9", uaddr(5), uaddr(1), 2'd1);
        req_time = 32'd205; send("R9", uaddr(1), uaddr(2), 2'd0);
        req_time = 32'd210; send("R7", uaddr(1), uaddr(2), 2'd0);
        req_time = 32'd211; send("R8", uaddr(1), uaddr(2), 2'd0);
        ttl = 32'd1000;     send("R8", uaddr(1), uaddr(2), 2'd0);
        // replacement
        do_reset();
        for (int k = 0; k < NE; k++) begin
            req_time = 32'(1000 + k);
            send("R11", '1, uaddr(20 + k), PW'(k % NP));
        end
        req_time = 32'd1010;
        send("R11", '1, uaddr(40), 2'd2);                // evicts uaddr(20)
        send("R11", uaddr(20), uaddr(40), 2'd1);
        send("R11", uaddr(21), uaddr(40), 2'd0);
        // wrap of the timestamp
        req_time = 32'hFFFF_FFFE; send("R7", '1, uaddr(50), 2'd3);
        req_time = 32'd3;         send("R7", uaddr(50), uaddr(40), 2'd0);
        // random traffic
        ttl = 32'd30;
        for (int n = 0; n < 600; n++) begin
            logic [47:0] d, s;
            int r = $urandom_range(0, 9);
            req_time = req_time + $urandom_range(0, 4);
            s = uaddr($urandom_range(0, 11));
            if (r == 0) d = 48'hFFFF_FFFF_FFFF;
            else if (r == 1) d = {8'h01, 8'h00, 32'($urandom_range(0, 3))};
            else if (r == 2) d = s;
            else d = uaddr($urandom_range(0, 11));
            if (n == 300) ttl = 32'd8;
            send("R11", d, s, PW'($urandom_range(0, NP - 1)));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule